// File: doc/BRIEF.md
# Edge-Selectable Port Wakeup Controller

The block watches a small group of port pins while the chip is idle and records, per channel, that a chosen transition has occurred. Every pin is first brought into the system clock domain by a synchronizer. Then a rising or a falling edge, chosen per channel, is detected. On a channel that is enabled, that edge sets a sticky pending bit. The pending bits are combined into one wakeup request, which the port interrupt enable gates. While the chip is asleep, the same request also drives a reset request toward the power sequencer.

Software sees two registers on a simple write/read bus. The control register holds the active-low channel enables in its low half and the pending bits in its high half. The edge register holds one edge-select bit per channel. A pending bit is cleared by writing 0 to its position, and the clear takes effect after a fixed delay. Writing 1 to a pending position leaves the bit unchanged. A channel that is disabled has its pending bit held at 0.

The register bus has no back-pressure: a write is accepted in the cycle `wr_en_i` is high, and read data is combinational from `rd_addr_i`.

Top module: `pwake_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x0F, the edge register (address 1) reads 0x00, and `pend_o`, `wake_o` and `rst_req_o` are 0.
- R2: Channel enables are active-low. Control register bit i (i = 0..NCH-1) equal to 1 disables channel i, so no transition on that channel's pin sets its pending bit.
- R3: In the edge register, bit i = 0 selects a rising edge and bit i = 1 selects a falling edge for channel i. A transition in the other direction does not set pending.
- R4: When the selected edge occurs on an enabled channel, pending bit i (control register bit NCH+i, also `pend_o[i]`) becomes 1. It stays 1 until it is cleared or disabled, and a write of 1 to that position leaves it at 1.
- R5: A write of 0 to pending position i clears that bit. The bit still reads 1 one clock edge after the write edge and reads 0 two clock edges after the write edge. If the clear and a new event fall on the same edge, the event wins.
- R6: When channel i's enable bit is 1, its pending bit is 0 from the clock edge after the enable bit becomes 1.
- R7: `wake_o` is 1 exactly when at least one pending bit is 1 and `port_ie_i` is 1.
- R8: `rst_req_o` is 1 exactly when `wake_o` is 1 and `sleep_i` is 1.
- R9: A pin change that is set up before clock edge A sets pending at edge A+2. Pending is still 0 after edge A+1.
- R10: Any write to address 1 loads edge-select bits from data bits [NCH-1:0]. Any write to address 0 loads the enables from data bits [NCH-1:0] and treats data bits [2*NCH-1:NCH] as the pending clear mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous pin levels, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 edge select |
| wr_data_i | input | 2*NCH | Write data |
| rd_addr_i | input | 1 | Read address: 0 control, 1 edge select |
| rd_data_o | output | 2*NCH | Read data of the addressed register |
| port_ie_i | input | 1 | Port interrupt enable that gates the wakeup request |
| sleep_i | input | 1 | High while the chip is in sleep |
| pend_o | output | NCH | Pending bits |
| wake_o | output | 1 | Combined wakeup request |
| rst_req_o | output | 1 | Reset request on wakeup from sleep |

## Verification
The bench builds the block with its defaults: four channels, a two-stage synchronizer and a two-cycle clear delay. With only four channels, every combination of channel, edge select, transition direction and enable state can be swept, which gives 32 cases, each predicted arithmetically. The short delay lines let the bench sample each cycle around the synchronizer latency and the delayed clear, so an off-by-one in either pipeline shows up as a mismatch.

// File: rtl/pwake_pkg.sv
package pwake_pkg;
  typedef enum logic {
    REG_CTL  = 1'b0,
    REG_EDGE = 1'b1
  } reg_sel_e;

  typedef enum logic {
    SEL_RISE = 1'b0,
    SEL_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/pwake_sync.sv
module pwake_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pwake_edge.sv
module pwake_edge
  import pwake_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] arm_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_ch
    logic rise, fall;
    assign rise     = lvl_i[i] & ~prev_q[i];
    assign fall     = ~lvl_i[i] & prev_q[i];
    assign evt_o[i] = arm_i[i] & ((sel_i[i] == SEL_FALL) ? fall : rise);
  end

  // R3: an event is only reported in a cycle where the level differs from the prior cycle
  p_evt_on_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_o & ~(lvl_i ^ $past(lvl_i))) == '0));
endmodule

// File: rtl/pwake_pend.sv
module pwake_pend #(
  parameter int W         = 4,
  parameter int CLR_DELAY = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] clr_req_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] dis_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] clr_line [CLR_DELAY];
  logic [W-1:0] clr_last;
  logic [W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < CLR_DELAY; k++) clr_line[k] <= '0;
    end else begin
      clr_line[0] <= clr_req_i;
      for (int k = 1; k < CLR_DELAY; k++) clr_line[k] <= clr_line[k-1];
    end
  end

  assign clr_last = clr_line[CLR_DELAY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= ((pend_q & ~clr_last) | evt_i) & ~dis_i;
  end

  assign pend_o = pend_q;

  // R4: a pending bit only rises after an event
  p_set_needs_event_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(evt_i)) == '0));
  // R5: a matured clear without a competing event leaves the bit at 0
  p_clear_applies_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(clr_last & ~evt_i)) == '0));
  // R6: a disabled channel has no pending bit on the next edge
  p_disabled_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(dis_i)) == '0));
endmodule

// File: rtl/pwake_ctrl.sv
module pwake_ctrl
  import pwake_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CLR_DELAY   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   pin_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [2*NCH-1:0] wr_data_i,
  input  logic             rd_addr_i,
  output logic [2*NCH-1:0] rd_data_o,
  input  logic             port_ie_i,
  input  logic             sleep_i,
  output logic [NCH-1:0]   pend_o,
  output logic             wake_o,
  output logic             rst_req_o
);
  localparam int BUS_W = 2 * NCH;

  logic [NCH-1:0] dis_q, sel_q, lvl, evt, clr_req, pend;
  logic           wr_ctl, wr_edge;

  assign wr_ctl  = wr_en_i && (wr_addr_i == REG_CTL);
  assign wr_edge = wr_en_i && (wr_addr_i == REG_EDGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= '1;
      sel_q <= '0;
    end else begin
      if (wr_ctl)  dis_q <= wr_data_i[NCH-1:0];
      if (wr_edge) sel_q <= wr_data_i[NCH-1:0];
    end
  end

  assign clr_req = wr_ctl ? ~wr_data_i[BUS_W-1:NCH] : '0;

  pwake_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl)
  );

  pwake_edge #(.W(NCH)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .sel_i(sel_q),
    .arm_i(~dis_q), .evt_o(evt)
  );

  pwake_pend #(.W(NCH), .CLR_DELAY(CLR_DELAY)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_req_i(clr_req), .evt_i(evt),
    .dis_i(dis_q), .pend_o(pend)
  );

  assign pend_o    = pend;
  assign wake_o    = (|pend) & port_ie_i;
  assign rst_req_o = wake_o & sleep_i;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == REG_CTL) rd_data_o = {pend, dis_q};
    else                      rd_data_o[NCH-1:0] = sel_q;
  end

  // R7: the wakeup request never asserts while the port interrupt is masked
  p_wake_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (port_ie_i && pend_o != '0));
  // R8: a reset request only appears during sleep with a wakeup pending
  p_rst_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (sleep_i && wake_o));
  // R2: a disabled channel never receives an event
  p_no_evt_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt & dis_q) == '0);
endmodule

// File: tb/tb_pwake_ctrl.sv
module tb_pwake_ctrl;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin = '0;
  logic           wr_en = 1'b0;
  logic           wr_addr = 1'b0;
  logic [7:0]     wr_data = '0;
  logic           rd_addr = 1'b0;
  logic [7:0]     rd_data;
  logic           port_ie = 1'b1;
  logic           sleep = 1'b0;
  logic [NCH-1:0] pend;
  logic           wake, rst_req;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pwake_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .CLR_DELAY(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .port_ie_i(port_ie), .sleep_i(sleep),
    .pend_o(pend), .wake_o(wake), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a; #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [3:0] en_n, input logic [3:0] sel, input logic [3:0] start);
    wr(1'b0, 8'h0F);
    pin = start;
    idle(6);
    wr(1'b1, {4'h0, sel});
    wr(1'b0, {4'h0, en_n});
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [3:0] expv;
    idle(3);
    // R1 reset state
    rd(1'b0, r); chk("R1 ctl reset", r, 8'h0F);
    rd(1'b1, r); chk("R1 edge reset", r, 8'h00);
    chk("R1 outputs", {5'b0, wake, rst_req, |pend}, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R4 sweep: channel x edge select x direction x enable
    for (int ch = 0; ch < NCH; ch++) begin
      for (int es = 0; es < 2; es++) begin
        for (int dir = 0; dir < 2; dir++) begin
          for (int en = 0; en < 2; en++) begin
            logic [3:0] start;
            start = (dir == 1) ? (4'b1 << ch) : 4'b0;
            setup(en ? ~(4'b1 << ch) : 4'hF, 4'(es) << ch, start);
            pin = start ^ (4'b1 << ch);
            idle(4);
            expv = (en == 1 && es == dir) ? (4'b1 << ch) : 4'b0;
            rd(1'b0, r);
            chk($sformatf("R2/R3/R4 ch%0d es%0d dir%0d en%0d", ch, es, dir, en),
                {r[7:4], 3'b0, wake}, {expv, 3'b0, (expv != 0)});
          end
        end
      end
    end
    // R10 edge register readback
    wr(1'b1, 8'h05);
    rd(1'b1, r); chk("R10 edge readback", r, 8'h05);

    // R9 synchronizer latency, channel 0 rising
    setup(4'hE, 4'h0, 4'h0);
    @(negedge clk); pin = 4'h1;
    idle(2); chk("R9 after A+1", {4'b0, pend}, 8'h00);
    idle(1); chk("R9 after A+2", {4'b0, pend}, 8'h01);

    // R4 write of 1 keeps the bit
    wr(1'b0, 8'hFE);
    idle(4); chk("R4 write one keeps", {4'b0, pend}, 8'h01);

    // R7 gating, R8 reset request
    port_ie = 1'b0; #1 chk("R7 masked", {7'b0, wake}, 8'h00);
    port_ie = 1'b1; #1 chk("R7 unmasked", {7'b0, wake}, 8'h01);
    sleep = 1'b1;   #1 chk("R8 asleep", {7'b0, rst_req}, 8'h01);
    sleep = 1'b0;   #1 chk("R8 awake", {7'b0, rst_req}, 8'h00);

    // R5 delayed clear
    wr(1'b0, 8'hEE);
    chk("R5 after E0", {4'b0, pend}, 8'h01);
    idle(1); chk("R5 after E0+1", {4'b0, pend}, 8'h01);
    idle(1); chk("R5 after E0+2", {4'b0, pend}, 8'h00);
    sleep = 1'b1; #1 chk("R8 no pending", {7'b0, rst_req}, 8'h00);
    sleep = 1'b0;

    // R6 disabling forces clear
    pin = 4'h0; idle(4); pin = 4'h1; idle(4);
    chk("R6 pre set", {4'b0, pend}, 8'h01);
    wr(1'b0, 8'hFF);
    idle(1); chk("R6 disabled clears", {4'b0, pend}, 8'h00);
    wr(1'b0, 8'hFE);
    idle(3); chk("R6 stays clear on reenable", {4'b0, pend}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule